// File: doc/BRIEF.md
# SDRAM Command Sequencer with Switchable Row Policy

This block turns single-beat host reads and writes into SDRAM command sequences. The host presents an address, a write flag, write data and byte enables with a valid strobe. It holds them until the block shows it is ready. It then waits for a one-cycle completion pulse, and read data is returned on that pulse. The block drives chip select, RAS, CAS, WE, the bank address, the multiplexed row/column address with the auto-precharge line at bit 10, the byte masks and the data bus.

Two row policies can be selected at run time. In the closing policy, every column command asks for auto-precharge, so no row stays open after an access. In the open-row policy, the block keeps a record per bank of whether a row is open and which row it is. An access that hits the open row goes straight to the column command. An access that misses precharges only that bank, waits out the precharge time and then reactivates. An input that signals a configuration with two SDRAM regions forces the closing policy. A refresh request closes every bank with a precharge-all, clears the records and issues an auto-refresh. Host requests are held off while this happens.

Top module: `sdram_seq`

## Requirements
- R1: After reset, the block shows ready, completion low, the data bus not driven, and a NOP on the command pins. Commands are encoded as {csN,rasN,casN,weN}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001.
- R2: In the closing policy, an access to a closed bank issues ACTIVATE with the row on the address pins, then the column command with address bit 10 high and the column in bits 7:0. No PRECHARGE command follows, and the next access to the same row activates again. The host address is {row[11:0], bank[1:0], col[7:0]}.
- R3: The column command follows ACTIVATE by exactly T_RCD clocks.
- R4: In the open-row policy, an access to the same bank and row as the open row issues only the column command, with bit 10 low.
- R5: In the open-row policy, a row miss issues PRECHARGE to that bank only, with bit 10 low. ACTIVATE for the new row follows T_RP clocks later. Rows open in other banks stay open and keep hitting.
- R6: A write drives the data bus for exactly one cycle, the WRITE cycle, with the write data on it and DQM equal to the inverted byte enables.
- R7: When the two-region input is high, the closing policy applies even with the open-row policy selected.
- R8: A refresh request issues PRECHARGE with bit 10 high and then REFRESH T_RP clocks later. Ready is low from the request until the refresh wait ends. Afterwards every bank counts as closed.
- R9: Read data is the value on the data-in bus CAS-latency (T_CL) clocks after the READ cycle. DQM is low during the READ command.
- R10: Switching from the open-row to the closing policy while a row is open makes the next access to that bank precharge it, activate it and issue the column command with bit 10 high.
- R11: Ready drops in the cycle after a request is accepted. The completion pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeOpenRow | input | 1 | 1 selects the open-row policy, 0 the closing policy |
| dualRegion | input | 1 | 1 when two SDRAM regions are configured; forces the closing policy |
| refreshReq | input | 1 | Refresh request pulse |
| reqValid | input | 1 | Host request valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 22 | {row, bank, column} |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, active high |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| respDone | output | 1 | One-cycle completion pulse |
| respRdata | output | 32 | Read data |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdAddr | output | 12 | Row address, or column with auto-precharge at bit 10 |
| sdDqm | output | 4 | Byte masks |
| sdDqOut | output | 32 | Data bus output |
| sdDqOe | output | 1 | Data bus output enable |
| sdDqIn | input | 32 | Data bus input |

## Verification
Two situations are hard to reach from the ports. The first is a row miss in one bank while another bank keeps its row open. The second is a policy switch while a row is still open. Both depend on the per-bank records, which cannot be seen directly. The directed tests build them up in steps: they open rows in two banks, force a miss on one bank, and then show through a single-command access that the other bank still hits. A separate test opens a row, flips the policy input, and observes the extra precharge. The memory side returns a value that changes every cycle, so the returned read data gives the exact capture cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdCmd_e;

  typedef struct packed {
    sdCmd_e cmd;
    logic   useRow;
    logic   a10;
    logic   driveData;
    logic   latchReq;
    logic   captureRd;
    logic   setOpen;
    logic   clearBank;
    logic   clearAll;
  } ctlStrobe_t;
endpackage

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        st,
  input  logic [ROW_W+BANK_W+COL_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic [DATA_W/8-1:0]               reqBe,
  input  logic [DATA_W-1:0]                 sdDqIn,
  output logic                              inOpen,
  output logic                              inHit,
  output logic [DATA_W-1:0]                 respRdata,
  output logic                              sdCsN,
  output logic                              sdRasN,
  output logic                              sdCasN,
  output logic                              sdWeN,
  output logic [BANK_W-1:0]                 sdBa,
  output logic [ROW_W-1:0]                  sdAddr,
  output logic [DATA_W/8-1:0]               sdDqm,
  output logic [DATA_W-1:0]                 sdDqOut,
  output logic                              sdDqOe
);
  localparam int NBANK   = 1 << BANK_W;
  localparam int BE_W    = DATA_W / 8;
  localparam int A10_POS = 10;

  logic [ROW_W-1:0]  latRow;
  logic [BANK_W-1:0] latBank;
  logic [COL_W-1:0]  latCol;
  logic [DATA_W-1:0] latWdata;
  logic [BE_W-1:0]   latBe;

  logic [NBANK-1:0]  openVld;
  logic [ROW_W-1:0]  openRow [NBANK];

  logic [ROW_W-1:0]  inRow;
  logic [BANK_W-1:0] inBank;
  assign inRow  = reqAddr[COL_W+BANK_W +: ROW_W];
  assign inBank = reqAddr[COL_W +: BANK_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latRow   <= '0;
      latBank  <= '0;
      latCol   <= '0;
      latWdata <= '0;
      latBe    <= '0;
    end else if (st.latchReq) begin
      latRow   <= inRow;
      latBank  <= inBank;
      latCol   <= reqAddr[COL_W-1:0];
      latWdata <= reqWdata;
      latBe    <= reqBe;
    end
  end

  // per-bank open-row record
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             vldQ;
    logic [ROW_W-1:0] rowQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldQ <= 1'b0;
        rowQ <= '0;
      end else if (st.clearAll) begin
        vldQ <= 1'b0;
      end else if (latBank == BANK_W'(b)) begin
        if (st.setOpen) begin
          vldQ <= 1'b1;
          rowQ <= latRow;
        end else if (st.clearBank) begin
          vldQ <= 1'b0;
        end
      end
    end
    assign openVld[b] = vldQ;
    assign openRow[b] = rowQ;
  end

  assign inOpen = openVld[inBank];
  assign inHit  = inOpen && (openRow[inBank] == inRow);

  logic [ROW_W-1:0] colWord;
  always_comb begin
    colWord = '0;
    colWord[COL_W-1:0] = latCol;
    colWord[A10_POS] = st.a10;
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = st.cmd;
  assign sdBa    = latBank;
  assign sdAddr  = st.useRow ? latRow : colWord;
  assign sdDqm   = st.driveData ? ~latBe : '0;
  assign sdDqOut = latWdata;
  assign sdDqOe  = st.driveData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respRdata <= '0;
    else if (st.captureRd) respRdata <= sdDqIn;
  end

  // R4: a column command without auto-precharge targets the recorded open row
  p_hit_col_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((st.cmd == CMD_RD || st.cmd == CMD_WR) && !st.a10)
      |-> (openVld[latBank] && openRow[latBank] == latRow));
  // R5: never activate a bank that still holds an open row
  p_act_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmd == CMD_ACT) |-> !openVld[latBank]);
  // R8: refresh only reaches the device with every bank closed
  p_ref_closed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.cmd == CMD_REF) |-> (openVld == '0));
  // R6: one data beat per write
  p_one_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |=> !sdDqOe);
endmodule

// File: rtl/sdram_seq_ctl.sv
module sdram_seq_ctl
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_WR  = 2,
  parameter int T_RP  = 2,
  parameter int T_CL  = 2,
  parameter int T_RFC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeOpenRow,
  input  logic       dualRegion,
  input  logic       refreshReq,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       inOpen,
  input  logic       inHit,
  output ctlStrobe_t st,
  output logic       reqReady,
  output logic       respDone
);
  localparam int CNT_W = $clog2(T_RCD + T_WR + T_RP + T_CL + T_RFC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ACT, S_COL, S_WAIT, S_RECOV, S_CAPT, S_FIN, S_PREALL, S_REF
  } state_e;

  state_e           state, stateN, tgt, tgtN, waitTgt;
  logic [CNT_W-1:0] cnt, cntN, waitLen;
  logic             doWait;
  logic             refPend, refPendN;
  logic             latWr, latWrN, latAuto, latAutoN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tgt     <= S_IDLE;
      cnt     <= '0;
      refPend <= 1'b0;
      latWr   <= 1'b0;
      latAuto <= 1'b1;
    end else begin
      state   <= stateN;
      tgt     <= tgtN;
      cnt     <= cntN;
      refPend <= refPendN;
      latWr   <= latWrN;
      latAuto <= latAutoN;
    end
  end

  always_comb begin
    st       = '{cmd: CMD_NOP, default: 1'b0};
    stateN   = state;
    tgtN     = tgt;
    cntN     = cnt;
    refPendN = refPend | refreshReq;
    latWrN   = latWr;
    latAutoN = latAuto;
    reqReady = 1'b0;
    respDone = 1'b0;
    doWait   = 1'b0;
    waitLen  = '0;
    waitTgt  = S_IDLE;
    unique case (state)
      S_IDLE: begin
        reqReady = !refPend && !refreshReq;
        if (refPend || refreshReq) begin
          stateN = S_PREALL;
        end else if (reqValid) begin
          st.latchReq = 1'b1;
          latWrN   = reqWrite;
          latAutoN = !(modeOpenRow && !dualRegion);
          if (inOpen && (!(modeOpenRow && !dualRegion) || !inHit)) stateN = S_PRE;
          else if (inOpen) stateN = S_COL;
          else stateN = S_ACT;
        end
      end
      S_PRE: begin
        st.cmd = CMD_PRE;
        st.clearBank = 1'b1;
        doWait = 1'b1; waitLen = CNT_W'(T_RP); waitTgt = S_ACT;
      end
      S_ACT: begin
        st.cmd = CMD_ACT;
        st.useRow = 1'b1;
        st.setOpen = !latAuto;
        doWait = 1'b1; waitLen = CNT_W'(T_RCD); waitTgt = S_COL;
      end
      S_COL: begin
        st.cmd = latWr ? CMD_WR : CMD_RD;
        st.a10 = latAuto;
        st.clearBank = latAuto;
        st.driveData = latWr;
        doWait = 1'b1;
        if (latWr) begin
          waitLen = CNT_W'(T_WR);
          waitTgt = latAuto ? S_RECOV : S_FIN;
        end else begin
          waitLen = CNT_W'(T_CL);
          waitTgt = S_CAPT;
        end
      end
      S_CAPT: begin
        st.captureRd = 1'b1;
        if (latAuto) begin
          doWait = 1'b1; waitLen = CNT_W'(T_RP); waitTgt = S_FIN;
        end else begin
          stateN = S_FIN;
        end
      end
      S_RECOV: begin
        doWait = 1'b1; waitLen = CNT_W'(T_RP); waitTgt = S_FIN;
      end
      S_FIN: begin
        respDone = 1'b1;
        stateN = S_IDLE;
      end
      S_PREALL: begin
        st.cmd = CMD_PRE;
        st.a10 = 1'b1;
        st.clearAll = 1'b1;
        doWait = 1'b1; waitLen = CNT_W'(T_RP); waitTgt = S_REF;
      end
      S_REF: begin
        st.cmd = CMD_REF;
        refPendN = refreshReq;
        doWait = 1'b1; waitLen = CNT_W'(T_RFC); waitTgt = S_IDLE;
      end
      S_WAIT: begin
        if (cnt <= CNT_W'(1)) stateN = tgt;
        else cntN = cnt - 1'b1;
      end
      default: stateN = S_IDLE;
    endcase
    if (doWait) begin
      if (waitLen <= CNT_W'(1)) begin
        stateN = waitTgt;
      end else begin
        stateN = S_WAIT;
        cntN   = waitLen - 1'b1;
        tgtN   = waitTgt;
      end
    end
  end

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);
  // R11: an accepted request makes the block busy on the next cycle
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int T_RCD  = 2,
  parameter int T_WR   = 2,
  parameter int T_RP   = 2,
  parameter int T_CL   = 2,
  parameter int T_RFC  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeOpenRow,
  input  logic                          dualRegion,
  input  logic                          refreshReq,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqBe,
  output logic                          reqReady,
  output logic                          respDone,
  output logic [DATA_W-1:0]             respRdata,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [DATA_W/8-1:0]           sdDqm,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe,
  input  logic [DATA_W-1:0]             sdDqIn
);
  ctlStrobe_t st;
  logic inOpen, inHit;

  sdram_seq_ctl #(
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .modeOpenRow(modeOpenRow), .dualRegion(dualRegion),
    .refreshReq(refreshReq), .reqValid(reqValid), .reqWrite(reqWrite),
    .inOpen(inOpen), .inHit(inHit), .st(st), .reqReady(reqReady), .respDone(respDone)
  );

  sdram_seq_dp #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .sdDqIn(sdDqIn), .inOpen(inOpen), .inHit(inHit),
    .respRdata(respRdata), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe)
  );
endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_WR = 2, T_RP = 3, T_CL = 2, T_RFC = 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;
  localparam logic [31:0] DQ_BASE = 32'hC0DE_0000;

  logic clk = 0, rstN = 0;
  logic modeOpenRow = 0, dualRegion = 0, refreshReq = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [21:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic reqReady, respDone, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [31:0] respRdata, sdDqOut;
  logic [31:0] sdDqIn = '0;
  logic [1:0]  sdBa;
  logic [11:0] sdAddr;
  logic [3:0]  sdDqm;

  int checks = 0, errors = 0, cyc = 0, logN = 0, oeCycles = 0;
  logic [3:0]  logCmd  [16];
  logic [1:0]  logBa   [16];
  logic [11:0] logAddr [16];
  int          logCyc  [16];
  logic [31:0] logDq   [16];
  logic [3:0]  logDqm  [16];
  logic        logOe   [16];
  bit busyReady, doneSeen, doneAfter, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_seq #(.T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC)) dut (
    .clk(clk), .rstN(rstN), .modeOpenRow(modeOpenRow), .dualRegion(dualRegion),
    .refreshReq(refreshReq), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .reqReady(reqReady), .respDone(respDone),
    .respRdata(respRdata), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqIn(sdDqIn));

  // command monitor and memory-side data source
  always @(negedge clk) begin
    cyc++;
    sdDqIn = DQ_BASE + 32'(cyc);
    if (sdDqOe) oeCycles++;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} != C_NOP && logN < 16) begin
      logCmd[logN]  = {sdCsN, sdRasN, sdCasN, sdWeN};
      logBa[logN]   = sdBa;
      logAddr[logN] = sdAddr;
      logCyc[logN]  = cyc;
      logDq[logN]   = sdDqOut;
      logDqm[logN]  = sdDqm;
      logOe[logN]   = sdDqOe;
      logN++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input bit wr, input logic [11:0] row, input logic [1:0] bank,
                          input logic [7:0] col, input logic [31:0] wd, input logic [3:0] be);
    int n = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logN = 0; oeCycles = 0;
    reqValid = 1; reqWrite = wr; reqAddr = {row, bank, col}; reqWdata = wd; reqBe = be;
    @(negedge clk);
    reqValid = 0;
    busyReady = reqReady;
    while (!respDone && n < 100) begin @(negedge clk); n++; end
    doneSeen = respDone;
    @(negedge clk);
    doneAfter = respDone;
  endtask

  task automatic tReset();
    check(reqReady === 1'b1, "R1 ready after reset", 32'(reqReady), 1);
    check(respDone === 1'b0, "R1 done after reset", 32'(respDone), 0);
    check(sdDqOe === 1'b0, "R1 bus idle after reset", 32'(sdDqOe), 0);
    check({sdCsN, sdRasN, sdCasN, sdWeN} === C_NOP, "R1 NOP after reset",
          32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'(C_NOP));
  endtask

  task automatic tAutoWrite();
    modeOpenRow = 0; dualRegion = 0;
    doAccess(1, 12'h123, 2'd1, 8'h45, 32'hDEAD_BEEF, 4'b0101);
    check(logN == 2, "R2 two commands", 32'(logN), 2);
    check(logCmd[0] == C_ACT && logBa[0] == 2'd1 && logAddr[0] == 12'h123,
          "R2 activate row", 32'({logCmd[0], logAddr[0]}), 32'({C_ACT, 12'h123}));
    check(logCmd[1] == C_WR && logAddr[1][10] && logAddr[1][7:0] == 8'h45,
          "R2 write with auto-precharge", 32'({logCmd[1], logAddr[1]}), 32'({C_WR, 12'h445}));
    check(logCyc[1] - logCyc[0] == T_RCD, "R3 activate to column delay",
          32'(logCyc[1] - logCyc[0]), T_RCD);
    check(logOe[1] && logDq[1] == 32'hDEAD_BEEF && logDqm[1] == 4'b1010,
          "R6 write beat data and mask", {logDq[1][27:0], logDqm[1]}, {28'hEAD_BEEF, 4'b1010});
    check(oeCycles == 1, "R6 single data beat", 32'(oeCycles), 1);
    check(busyReady == 0, "R11 ready low after accept", 32'(busyReady), 0);
    check(doneSeen && !doneAfter, "R11 one-cycle done", {30'd0, doneSeen, doneAfter}, 2);
    doAccess(1, 12'h123, 2'd1, 8'h46, 32'h1111_2222, 4'b1111);
    check(logN == 2 && logCmd[0] == C_ACT, "R2 row closed after access",
          32'(logCmd[0]), 32'(C_ACT));
  endtask

  task automatic tOpenReadHit();
    modeOpenRow = 1; dualRegion = 0;
    doAccess(0, 12'h050, 2'd2, 8'h10, '0, '0);
    check(logN == 2 && logCmd[0] == C_ACT && logCmd[1] == C_RD && !logAddr[1][10],
          "R4 open read leaves row open", 32'({logCmd[1], logAddr[1]}), 32'({C_RD, 12'h010}));
    check(logDqm[1] == 4'b0000, "R9 DQM low on read", 32'(logDqm[1]), 0);
    check(respRdata == DQ_BASE + 32'(logCyc[1] + T_CL), "R9 read capture cycle",
          respRdata, DQ_BASE + 32'(logCyc[1] + T_CL));
    doAccess(0, 12'h050, 2'd2, 8'h11, '0, '0);
    check(logN == 1 && logCmd[0] == C_RD && !logAddr[0][10] && logAddr[0][7:0] == 8'h11,
          "R4 hit issues only READ", 32'(logN), 1);
    check(respRdata == DQ_BASE + 32'(logCyc[0] + T_CL), "R9 hit read data",
          respRdata, DQ_BASE + 32'(logCyc[0] + T_CL));
  endtask

  task automatic tOpenMiss();
    modeOpenRow = 1; dualRegion = 0;
    doAccess(0, 12'h010, 2'd3, 8'h00, '0, '0);
    doAccess(1, 12'h077, 2'd2, 8'h20, 32'hA5A5_0001, 4'b0011);
    check(logN == 3 && logCmd[0] == C_PRE && logBa[0] == 2'd2 && !logAddr[0][10],
          "R5 miss precharges one bank", 32'({logCmd[0], logAddr[0]}), 32'({C_PRE, 12'h000}));
    check(logCmd[1] == C_ACT && logAddr[1] == 12'h077 && logCyc[1] - logCyc[0] == T_RP,
          "R5 reactivate after precharge time", 32'(logCyc[1] - logCyc[0]), T_RP);
    check(logCmd[2] == C_WR && !logAddr[2][10] && logCyc[2] - logCyc[1] == T_RCD,
          "R3 miss column delay", 32'(logCyc[2] - logCyc[1]), T_RCD);
    doAccess(0, 12'h010, 2'd3, 8'h01, '0, '0);
    check(logN == 1 && logCmd[0] == C_RD, "R5 other bank kept open", 32'(logN), 1);
  endtask

  task automatic tDualForce();
    modeOpenRow = 1; dualRegion = 1;
    doAccess(1, 12'h200, 2'd0, 8'h01, 32'h0BAD_F00D, 4'b1000);
    check(logN == 2 && logCmd[1] == C_WR && logAddr[1][10], "R7 forced auto-precharge",
          32'(logAddr[1]), 32'h401);
    doAccess(1, 12'h200, 2'd0, 8'h02, 32'h0BAD_F00E, 4'b1000);
    check(logN == 2 && logCmd[0] == C_ACT, "R7 row not kept", 32'(logCmd[0]), 32'(C_ACT));
    dualRegion = 0;
  endtask

  task automatic tModeSwitch();
    modeOpenRow = 1; dualRegion = 0;
    doAccess(0, 12'h300, 2'd1, 8'h05, '0, '0);
    modeOpenRow = 0;
    doAccess(0, 12'h300, 2'd1, 8'h06, '0, '0);
    check(logN == 3 && logCmd[0] == C_PRE && logBa[0] == 2'd1 && logCmd[1] == C_ACT,
          "R10 switch closes open row", 32'(logCmd[0]), 32'(C_PRE));
    check(logCmd[2] == C_RD && logAddr[2][10], "R10 column with auto-precharge",
          32'(logAddr[2]), 32'h406);
  endtask

  task automatic tRefresh();
    int n = 0;
    modeOpenRow = 1;
    doAccess(0, 12'h011, 2'd0, 8'h00, '0, '0);
    @(negedge clk);
    logN = 0;
    refreshReq = 1;
    #1;
    check(reqReady == 0, "R8 requests held during refresh", 32'(reqReady), 0);
    @(negedge clk);
    refreshReq = 0;
    check(reqReady == 0, "R8 still held", 32'(reqReady), 0);
    while (!reqReady && n < 100) begin @(negedge clk); n++; end
    check(logN == 2 && logCmd[0] == C_PRE && logAddr[0][10], "R8 precharge all",
          32'({logCmd[0], logAddr[0]}), 32'({C_PRE, 12'h400}));
    check(logCmd[1] == C_REF && logCyc[1] - logCyc[0] == T_RP, "R8 refresh after tRP",
          32'(logCyc[1] - logCyc[0]), T_RP);
    doAccess(0, 12'h011, 2'd0, 8'h01, '0, '0);
    check(logN == 2 && logCmd[0] == C_ACT, "R8 records cleared", 32'(logCmd[0]), 32'(C_ACT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tAutoWrite();
    tOpenReadHit();
    tOpenMiss();
    tDualForce();
    tModeSwitch();
    tRefresh();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule